// File: doc/BRIEF.md
# DMA Channel Completion, Reload and Interrupt Controller

This block sits at the end of each DMA channel's transfer engine and decides what happens when a transfer finishes. The engine reports a completion together with its causes: terminal count, end-of-process and pattern match. The block latches these causes. It pulses a shared end-of-process output. Using three enable groups in the channel's mode low word, it decides whether to raise an interrupt, whether to copy the base registers back into the current registers (a strobe to the register file), and whether to start a chain load (a strobe to the chain fetcher).

An interrupt raised while the same channel still has one outstanding is not lost. The block records it as a second pending interrupt. It stalls the channel, so further completions are refused, and it holds back the reload and chain decisions for that completion. When the processor acknowledges, the block returns a 16-bit vector/status word. If a second interrupt was waiting, that acknowledge also releases the deferred reload and chain strobes and leaves the interrupt raised for the held-back event.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: An accepted completion replaces the channel's latched causes with the new ones (cause bit 0 end-of-process, bit 1 match, bit 2 terminal count), sets the channel's no-reload flag, and pulses `eop_o` high for exactly one cycle, one cycle after the completion is presented.
- R2: A completion raises the channel's pending interrupt when any of its causes has its enable set in mode bits 9:7. Within that group, bit 7 enables end-of-process, bit 8 enables match and bit 9 enables terminal count.
- R3: `irq_o` is high exactly when some channel has a pending interrupt and its `int_en_i` bit is high.
- R4: When no second interrupt is recorded, a completion whose causes meet the reload enables in mode bits 12:10 (same bit order as R2) pulses that channel's `reload_o` for one cycle, one cycle later, and clears the no-reload flag.
- R5: Under the same condition, causes meeting the chain enables in mode bits 15:13 (same bit order) pulse that channel's `chain_o` for one cycle, one cycle later.
- R6: A completion that would raise an interrupt while that channel already has one pending sets the channel's second-pending flag, shown on `stall_o`. That completion then produces no `reload_o` and no `chain_o` pulse.
- R7: While a channel's `stall_o` is high, completions presented on that channel are ignored: its causes, flags and strobes are unchanged and no `eop_o` pulse results.
- R8: An `ack_i` pulse serves the lowest-numbered channel that has a pending interrupt and `int_en_i` high, and clears that channel's pending interrupt. One cycle later, `ack_data_o` holds the word {channel index[15:13], no-reload[12], terminal count[11], match[10], end-of-process[9], second-pending[8], vector[7:0]}. All fields are taken from the state before the acknowledge, and the word is held until the next acknowledge.
- R9: Acknowledging a channel whose second-pending flag is set clears that flag, leaves the interrupt pending, and releases the deferred reload and chain strobes, evaluated from the latched causes against the current mode. The strobes appear one cycle after the acknowledge, and a released reload clears the no-reload flag.
- R10: When `vec_off_i` is high, an acknowledge still clears state as in R8 and R9, but `ack_data_o` becomes 0.
- R11: An acknowledge when no channel is both pending and enabled sets `ack_data_o` to 0 and changes no channel state.
- R12: When an acknowledge and a completion hit the same channel in the same cycle, the acknowledge word reflects the state before both. The completion is then applied to the state the acknowledge left, so a new interrupt becomes the only pending one rather than a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmpl_vld_i | input | NCH | Per-channel completion strobe |
| cmpl_cause_i | input | 3*NCH | Per-channel causes {tc, match, eop} |
| mode_lo_i | input | 16*NCH | Per-channel mode low word (enable groups at 15:7) |
| int_en_i | input | NCH | Per-channel interrupt enable |
| vec_i | input | 8*NCH | Per-channel interrupt vector |
| vec_off_i | input | 1 | Return zero on acknowledge |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| ack_data_o | output | 16 | Vector/status word of the last acknowledge |
| eop_o | output | 1 | End-of-process pulse |
| reload_o | output | NCH | Base-to-current copy strobe per channel |
| chain_o | output | NCH | Chain load start strobe per channel |
| stall_o | output | NCH | Second interrupt pending; channel held |

## Verification
The delicate overlap is an acknowledge that lands in the same cycle as a completion on the same channel. Two cases matter: a plain pending interrupt, and a recorded second interrupt. In the second case, the acknowledge releases a deferred reload while the stalled channel must still refuse the new completion. The bench provokes both cases on purpose and again through a long random stretch with frequent acknowledges. A behavioural model orders the acknowledge before the completion, and every output is compared with that model on every clock.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;

    localparam int CAUSE_W     = 3;
    localparam int MODE_W      = 16;
    localparam int VEC_W       = 8;
    localparam int WORD_W      = 16;
    localparam int IDX_W       = 3;
    localparam int GRP_INT_LSB = 7;
    localparam int GRP_RLD_LSB = 10;
    localparam int GRP_CHN_LSB = 13;

    // bit 0 end-of-process, bit 1 match, bit 2 terminal count
    typedef struct packed {
        logic tc;
        logic mc;
        logic eop;
    } cause_t;

    typedef struct packed {
        logic   pend;
        logic   sip;
        logic   nar;
        cause_t cause;
        logic   rl;
        logic   chn;
        logic   eop;
    } chan_st_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [IDX_W-1:0] idx,
        input chan_st_t         st,
        input logic [VEC_W-1:0] vec
    );
        return {idx, st.nar, st.cause.tc, st.cause.mc, st.cause.eop, st.sip, vec};
    endfunction

endpackage

// File: rtl/cmpl_chan.sv
module cmpl_chan
    import cmpl_irq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cmpl_vld_i,
    input  logic [CAUSE_W-1:0]  cmpl_cause_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                ack_take_i,
    output chan_st_t            st_o
);

    chan_st_t st_d, st_q;
    cause_t   cin;
    logic [CAUSE_W-1:0] en_int, en_rld, en_chn;
    logic unused_mode_lo;

    assign cin    = cause_t'(cmpl_cause_i);
    assign en_int = mode_i[GRP_INT_LSB +: CAUSE_W];
    assign en_rld = mode_i[GRP_RLD_LSB +: CAUSE_W];
    assign en_chn = mode_i[GRP_CHN_LSB +: CAUSE_W];
    assign unused_mode_lo = ^mode_i[GRP_INT_LSB-1:0];

    always_comb begin
        st_d     = st_q;
        st_d.rl  = 1'b0;
        st_d.chn = 1'b0;
        st_d.eop = 1'b0;

        // acknowledge first: clear, or release the held-back event
        if (ack_take_i) begin
            st_d.pend = 1'b0;
            if (st_q.sip) begin
                st_d.sip  = 1'b0;
                st_d.pend = 1'b1;
                if (|(st_q.cause & en_rld)) begin
                    st_d.rl  = 1'b1;
                    st_d.nar = 1'b0;
                end
                st_d.chn = |(st_q.cause & en_chn);
            end
        end

        // completion, applied to the post-acknowledge state; refused while stalled
        if (cmpl_vld_i && !st_q.sip) begin
            st_d.cause = cin;
            st_d.nar   = 1'b1;
            st_d.eop   = 1'b1;
            if (|(cin & en_int)) begin
                if (st_d.pend) st_d.sip  = 1'b1;
                else           st_d.pend = 1'b1;
            end
            if (!st_d.sip) begin
                if (|(cin & en_rld)) begin
                    st_d.rl  = 1'b1;
                    st_d.nar = 1'b0;
                end
                st_d.chn = |(cin & en_chn);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign st_o = st_q;

    assert_sip_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.sip |-> st_q.pend);

    assert_no_strobe_on_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.sip) |-> !(st_q.rl || st_q.chn));

    assert_stall_refuses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sip && cmpl_vld_i) |=> ($stable(st_q.cause) && !st_q.eop));

    assert_reraise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.sip) |-> st_q.pend);

endmodule

// File: rtl/cmpl_ack_sel.sv
module cmpl_ack_sel
    import cmpl_irq_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0]   req_i,
    output logic [NCH-1:0]   grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
    import cmpl_irq_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NCH-1:0]         cmpl_vld_i,
    input  logic [NCH*CAUSE_W-1:0] cmpl_cause_i,
    input  logic [NCH*MODE_W-1:0]  mode_lo_i,
    input  logic [NCH-1:0]         int_en_i,
    input  logic [NCH*VEC_W-1:0]   vec_i,
    input  logic                   vec_off_i,
    input  logic                   ack_i,
    output logic                   irq_o,
    output logic [WORD_W-1:0]      ack_data_o,
    output logic                   eop_o,
    output logic [NCH-1:0]         reload_o,
    output logic [NCH-1:0]         chain_o,
    output logic [NCH-1:0]         stall_o
);

    chan_st_t           st   [NCH];
    logic [NCH-1:0]     pend, eop_v, grant, take;
    logic               any;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  ack_d, ack_q;
    chan_st_t           sel_st;
    logic [VEC_W-1:0]   sel_vec;

    assign take = ack_i ? grant : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cmpl_chan u_chan (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .cmpl_vld_i   (cmpl_vld_i[c]),
            .cmpl_cause_i (cmpl_cause_i[c*CAUSE_W +: CAUSE_W]),
            .mode_i       (mode_lo_i[c*MODE_W +: MODE_W]),
            .ack_take_i   (take[c]),
            .st_o         (st[c])
        );
        assign pend[c]     = st[c].pend;
        assign eop_v[c]    = st[c].eop;
        assign reload_o[c] = st[c].rl;
        assign chain_o[c]  = st[c].chn;
        assign stall_o[c]  = st[c].sip;
    end

    cmpl_ack_sel #(.NCH(NCH)) u_sel (
        .req_i   (pend & int_en_i),
        .grant_o (grant),
        .any_o   (any),
        .idx_o   (idx)
    );

    always_comb begin
        sel_st  = '0;
        sel_vec = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) begin
                sel_st  = st[i];
                sel_vec = vec_i[i*VEC_W +: VEC_W];
            end
        end
    end

    always_comb begin
        ack_d = ack_q;
        if (ack_i) begin
            if (any && !vec_off_i) ack_d = pack_word(idx, sel_st, sel_vec);
            else                   ack_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= '0;
        else         ack_q <= ack_d;
    end

    assign ack_data_o = ack_q;
    assign irq_o      = |(pend & int_en_i);
    assign eop_o      = |eop_v;

    assert_ack_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !irq_o) |=> (ack_data_o == '0));

    assert_vec_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && vec_off_i) |=> (ack_data_o == '0));

    assert_eop_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmpl_vld_i == '0) |=> !eop_o);

    assert_ack_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_i |=> $stable(ack_data_o));

endmodule

// File: tb/sim_cmpl_irq_ctrl.sv
module sim_cmpl_irq_ctrl;

    localparam int N = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cmpl_vld = '0;
    logic [3*N-1:0]  cmpl_cause = '0;
    logic [16*N-1:0] mode_lo = '0;
    logic [N-1:0]    int_en = '1;
    logic [8*N-1:0]  vec = {8'hC3, 8'h5A};
    logic            vec_off = 1'b0;
    logic            ack = 1'b0;

    logic            irq;
    logic [15:0]     ack_data;
    logic            eop;
    logic [N-1:0]    reload, chain, stall;

    always #4 clk = ~clk;

    cmpl_irq_ctrl #(.NCH(N)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cmpl_vld_i(cmpl_vld), .cmpl_cause_i(cmpl_cause),
        .mode_lo_i(mode_lo), .int_en_i(int_en), .vec_i(vec), .vec_off_i(vec_off),
        .ack_i(ack), .irq_o(irq), .ack_data_o(ack_data), .eop_o(eop),
        .reload_o(reload), .chain_o(chain), .stall_o(stall)
    );

    // behavioural reference state
    bit       m_pend [N];
    bit       m_sip  [N];
    bit       m_nar  [N];
    bit [2:0] m_cause[N];
    bit       m_rl   [N];
    bit       m_chn  [N];
    bit       m_eop;
    bit [15:0] m_ack;

    int checks = 0;
    int errors = 0;
    string tag = "R3";

    function automatic bit [2:0] grp(int c, int lsb);
        return mode_lo[c*16 + lsb +: 3];
    endfunction

    function automatic bit [15:0] mk_mode(bit [2:0] ig, bit [2:0] rg, bit [2:0] cg);
        return {cg, rg, ig, 7'b0};
    endfunction

    task automatic model_update();
        int win = -1;
        bit old_sip;
        m_eop = 0;
        if (ack) begin
            for (int c = N - 1; c >= 0; c--)
                if (m_pend[c] && int_en[c]) win = c;
            if (win < 0 || vec_off) m_ack = 16'h0;
            else m_ack = {3'(win), m_nar[win], m_cause[win], m_sip[win], vec[win*8 +: 8]};
        end
        for (int c = 0; c < N; c++) begin
            m_rl[c] = 0;
            m_chn[c] = 0;
            old_sip = m_sip[c];
            if (c == win) begin
                if (m_sip[c]) begin
                    m_sip[c] = 0;
                    m_rl[c]  = (m_cause[c] & grp(c, 10)) != 0;
                    m_chn[c] = (m_cause[c] & grp(c, 13)) != 0;
                    if (m_rl[c]) m_nar[c] = 0;
                end else begin
                    m_pend[c] = 0;
                end
            end
            if (cmpl_vld[c] && !old_sip) begin
                m_cause[c] = cmpl_cause[c*3 +: 3];
                m_nar[c] = 1;
                m_eop = 1;
                if ((m_cause[c] & grp(c, 7)) != 0) begin
                    if (m_pend[c]) m_sip[c] = 1;
                    m_pend[c] = 1;
                end
                if (!m_sip[c]) begin
                    m_rl[c]  = (m_cause[c] & grp(c, 10)) != 0;
                    m_chn[c] = (m_cause[c] & grp(c, 13)) != 0;
                    if (m_rl[c]) m_nar[c] = 0;
                end
            end
        end
    endtask

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit m_irq = 0;
        bit [N-1:0] erl, ech, est;
        for (int c = 0; c < N; c++) begin
            if (m_pend[c] && int_en[c]) m_irq = 1;
            erl[c] = m_rl[c];
            ech[c] = m_chn[c];
            est[c] = m_sip[c];
        end
        chk("irq R3", 16'(irq), 16'(m_irq));
        chk("eop R1", 16'(eop), 16'(m_eop));
        chk("reload R4", 16'(reload), 16'(erl));
        chk("chain R5", 16'(chain), 16'(ech));
        chk("stall R6", 16'(stall), 16'(est));
        chk("ack_data R8", ack_data, m_ack);
    endtask

    task automatic step(bit [N-1:0] v, bit [3*N-1:0] cs, bit a);
        cmpl_vld = v;
        cmpl_cause = cs;
        ack = a;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        cmpl_vld = '0;
        ack = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_pend[c] = 0; m_sip[c] = 0; m_nar[c] = 0; m_cause[c] = 0;
            m_rl[c] = 0; m_chn[c] = 0;
        end
        m_eop = 0;
        m_ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R3 reset";
        compare();

        // R2 R4: terminal count with interrupt and reload enabled on channel 0
        tag = "R2";
        mode_lo[15:0] = mk_mode(3'b100, 3'b100, 3'b000);
        step(2'b01, 6'b000_100, 0);
        step(0, 0, 0);
        // R8: acknowledge returns the packed word, clears the interrupt
        tag = "R8";
        step(0, 0, 1);
        chk("ack word R8", ack_data, {3'd0, 1'b0, 3'b100, 1'b0, 8'h5A});
        step(0, 0, 0);

        // R5: end-of-process starts a chain load, no reload so no-reload flag stays set
        tag = "R5";
        mode_lo[15:0] = mk_mode(3'b001, 3'b000, 3'b001);
        step(2'b01, 6'b000_001, 0);
        step(0, 0, 1);
        chk("ack word R1", ack_data, {3'd0, 1'b1, 3'b001, 1'b0, 8'h5A});

        // R6 R7 R9: second interrupt held back, stall refuses completions
        tag = "R6";
        mode_lo[15:0] = mk_mode(3'b111, 3'b010, 3'b010);
        step(2'b01, 6'b000_010, 0);
        step(2'b01, 6'b000_010, 0);
        chk("stall set R6", 16'(stall[0]), 16'd1);
        tag = "R7";
        step(2'b01, 6'b000_100, 0);
        step(0, 0, 0);
        tag = "R9";
        step(0, 0, 1);
        chk("deferred reload R9", 16'(reload[0]), 16'd1);
        chk("still raised R9", 16'(irq), 16'd1);
        step(0, 0, 1);
        step(0, 0, 0);

        // R10: vector suppressed
        tag = "R10";
        step(2'b10, 6'b001_000, 0);
        mode_lo[31:16] = mk_mode(3'b111, 3'b000, 3'b000);
        step(2'b10, 6'b001_000, 0);
        vec_off = 1'b1;
        step(0, 0, 1);
        chk("zero word R10", ack_data, 16'h0);
        vec_off = 1'b0;

        // R11: acknowledge with nothing pending and enabled
        tag = "R11";
        step(0, 0, 1);
        step(2'b10, 6'b100_000, 0);
        int_en = 2'b01;
        step(0, 0, 1);
        chk("empty ack R11", ack_data, 16'h0);
        int_en = 2'b11;

        // R8 priority: both channels pending, channel 0 served first
        tag = "R8";
        step(2'b01, 6'b000_100, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 1);

        // R12: acknowledge and completion together, plain and stalled
        tag = "R12";
        step(2'b01, 6'b000_001, 0);
        step(2'b01, 6'b000_100, 1);
        step(2'b01, 6'b000_010, 0);
        step(2'b01, 6'b000_001, 1);
        step(0, 0, 1);
        step(0, 0, 1);

        // mixed traffic against the model
        tag = "R12 random";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0)
                mode_lo = {$urandom(), $urandom()};
            if ($urandom_range(0, 31) == 0)
                int_en = 2'($urandom());
            vec_off = ($urandom_range(0, 9) == 0);
            step(2'($urandom()) & 2'($urandom()), 6'($urandom()),
                 $urandom_range(0, 2) == 0);
        end
        vec_off = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule